// File: doc/BRIEF.md
# Bus Port Halt Handshake Controller

This block quiesces one bus port before the power to the logic behind it is removed. A single-cycle command starts a halt attempt. If the port already reports idle, the attempt finishes at once and the halt request is never raised. Otherwise the block raises the halt request and polls the port's acknowledge once per millisecond tick. It gives up after a bounded number of ticks.

When the wait ends, by acknowledge or by running out of ticks, the block samples the port's idle flag. A low idle flag marks the attempt as failed. Success is judged only by that idle flag, never by the acknowledge. The halt request is dropped at the end on both outcomes. The port itself stays halted until its own reset. A one-cycle completion pulse closes every attempt. The failure flag then holds its value until the next command is accepted.

The idle and acknowledge inputs come from the port's clock domain and pass through a synchronizer of configurable depth. The millisecond tick is a single-cycle strobe in the controller's own clock domain.

Top module: `port_halt_seq`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, `halt_req`, `halt_done` and `halt_fail` are all 0.
- R2: When a command is accepted while the synchronized idle flag is 1, `halt_done` pulses, `halt_req` stays 0 for the whole attempt, and `halt_fail` ends at 0.
- R3: When a command is accepted while the synchronized idle flag is 0, `halt_req` is 1 from the next cycle and stays 1 until the attempt ends.
- R4: The acknowledge is examined only in cycles where `ms_tick` is 1. An acknowledge that rises and falls between ticks does not end the wait. An acknowledge seen on a tick ends the wait, and `halt_done` follows two cycles after that tick.
- R5: Without an acknowledge, the wait ends on the POLL_LIMIT-th tick after the request is raised (default 100). After POLL_LIMIT-1 ticks, `halt_req` is still 1.
- R6: At the end of a wait, `halt_fail` is set to the inverse of the synchronized idle flag. An acknowledge with idle 0 gives failure. A timeout with idle 1 gives success.
- R7: `halt_req` returns to 0 in the same cycle that `halt_done` goes to 1, whether the attempt succeeded or failed.
- R8: `halt_done` is high for exactly one cycle per attempt.
- R9: `halt_fail` keeps its value between attempts and is cleared only when the next command is accepted.
- R10: A command is accepted only when no attempt is running and `halt_done` is 0. A command raised during a wait neither restarts nor extends the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_cmd | input | 1 | Start a halt attempt (accepted per R10) |
| ms_tick | input | 1 | One-cycle millisecond strobe that paces polling and timeout |
| port_idle | input | 1 | Port reports no outstanding traffic (asynchronous, synchronized) |
| port_ack | input | 1 | Port acknowledges the halt request (asynchronous, synchronized) |
| halt_req | output | 1 | Halt request to the port |
| halt_done | output | 1 | One-cycle completion pulse |
| halt_fail | output | 1 | Last attempt ended with the port not idle |

## Verification
The delicate coincidence is an acknowledge that lands on the very tick that exhausts the poll budget. The acknowledge branch and the timeout branch then both claim the same cycle. The bench provokes it by raising the acknowledge just before the POLL_LIMIT-th tick. It requires one completion exactly at that tick, with the outcome set only by the idle flag. A second coincidence is a command arriving during a wait. The bench requires that this command leaves the tick count to completion unchanged and yields a single done pulse.

// File: rtl/port_halt_pkg.sv
package port_halt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_FINISH = 2'd2
  } ph_state_t;

  localparam int unsigned PH_STATUS_W = 2;
  localparam int unsigned PH_BIT_IDLE = 0;
  localparam int unsigned PH_BIT_ACK  = 1;

endpackage

// File: rtl/ph_status_sync.sv
module ph_status_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            stage_q[s] <= '0;
          end else if (s == 0) begin
            stage_q[s] <= d_async;
          end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
          end
        end
      end
      assign q_sync = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ph_poll_counter.sv
module ph_poll_counter #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
    end else if (step && (count_q != LAST_VAL)) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign last = (count_q == LAST_VAL);

endmodule

// File: rtl/ph_seq_fsm.sv
module ph_seq_fsm
  import port_halt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd,
  input  logic      tick,
  input  logic      idle_s,
  input  logic      ack_s,
  input  logic      budget_last,
  output logic      cnt_clear,
  output logic      cnt_step,
  output logic      accept,
  output logic      req_q,
  output logic      done_q,
  output logic      fail_q,
  output ph_state_t state_q
);

  logic wait_over;

  assign accept    = (state_q == PH_IDLE) && cmd && !done_q;
  assign wait_over = tick && (ack_s || budget_last);
  assign cnt_clear = (state_q != PH_WAIT);
  assign cnt_step  = (state_q == PH_WAIT) && tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PH_IDLE: begin
          if (accept) begin
            fail_q <= 1'b0;
            if (idle_s) begin
              done_q <= 1'b1;
            end else begin
              req_q   <= 1'b1;
              state_q <= PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (wait_over) begin
            state_q <= PH_FINISH;
          end
        end
        PH_FINISH: begin
          req_q   <= 1'b0;
          done_q  <= 1'b1;
          fail_q  <= ~idle_s;
          state_q <= PH_IDLE;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/port_halt_seq.sv
module port_halt_seq
  import port_halt_pkg::*;
#(
  parameter int unsigned POLL_LIMIT  = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_cmd,
  input  logic ms_tick,
  input  logic port_idle,
  input  logic port_ack,
  output logic halt_req,
  output logic halt_done,
  output logic halt_fail
);

  logic [PH_STATUS_W-1:0] status_raw;
  logic [PH_STATUS_W-1:0] status_sync;
  logic                   idle_sync;
  logic                   ack_sync;
  logic                   budget_last;
  logic                   cnt_clear;
  logic                   cnt_step;
  logic                   cmd_accept;
  ph_state_t              seq_state;

  assign status_raw[PH_BIT_IDLE] = port_idle;
  assign status_raw[PH_BIT_ACK]  = port_ack;

  ph_status_sync #(
    .WIDTH (PH_STATUS_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(status_raw),
    .q_sync (status_sync)
  );

  assign idle_sync = status_sync[PH_BIT_IDLE];
  assign ack_sync  = status_sync[PH_BIT_ACK];

  ph_poll_counter #(
    .LIMIT(POLL_LIMIT)
  ) u_budget (
    .clk  (clk),
    .rst  (rst),
    .clear(cnt_clear),
    .step (cnt_step),
    .last (budget_last)
  );

  ph_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd        (halt_cmd),
    .tick       (ms_tick),
    .idle_s     (idle_sync),
    .ack_s      (ack_sync),
    .budget_last(budget_last),
    .cnt_clear  (cnt_clear),
    .cnt_step   (cnt_step),
    .accept     (cmd_accept),
    .req_q      (halt_req),
    .done_q     (halt_done),
    .fail_q     (halt_fail),
    .state_q    (seq_state)
  );

endmodule

// File: rtl/port_halt_chk.sv
module port_halt_chk #(
  parameter int unsigned POLL_LIMIT = 100
) (
  input logic clk,
  input logic rst,
  input logic ms_tick,
  input logic halt_req,
  input logic halt_done,
  input logic halt_fail,
  input logic accept,
  input logic idle_s,
  input logic ack_s
);

  localparam int unsigned TW = $clog2(POLL_LIMIT + 3);

  logic          rst_seen = 1'b0;
  logic [TW-1:0] req_ticks;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst || !halt_req) begin
      req_ticks <= '0;
    end else if (ms_tick && (req_ticks != {TW{1'b1}})) begin
      req_ticks <= req_ticks + 1'b1;
    end
  end

  // R1: outputs quiet in the cycle after reset was sampled
  always @(posedge clk) begin
    if (rst_seen) begin
      p_reset_quiet_r1: assert (!halt_req && !halt_done && !halt_fail);
    end
  end

  p_idle_skips_req_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && idle_s) |=> (!halt_req && halt_done && !halt_fail));

  p_busy_raises_req_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !idle_s) |=> halt_req);

  p_ack_ends_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !halt_done && ms_tick && ack_s) |=> ##1 halt_done);

  // R5: one extra tick may land in the final cycle before the request drops
  p_tick_budget_r5: assert property (@(posedge clk) disable iff (rst)
    req_ticks <= TW'(POLL_LIMIT + 1));

  p_req_drop_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(halt_req) |-> halt_done);

  p_done_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    halt_done |-> !halt_req);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    halt_done |=> !halt_done);

  p_fail_holds_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(halt_fail) |-> (halt_done || $past(accept)));

  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> !accept);

endmodule

bind port_halt_seq port_halt_chk #(
  .POLL_LIMIT(POLL_LIMIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ms_tick  (ms_tick),
  .halt_req (halt_req),
  .halt_done(halt_done),
  .halt_fail(halt_fail),
  .accept   (cmd_accept),
  .idle_s   (idle_sync),
  .ack_s    (ack_sync)
);

// File: tb/sim_port_halt_seq.sv
`timescale 1ns/1ps
module sim_port_halt_seq;

  localparam int LIMIT = 100;
  localparam int NEVER = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_cmd = 1'b0;
  logic ms_tick = 1'b0;
  logic port_idle = 1'b0;
  logic port_ack = 1'b0;
  logic halt_req;
  logic halt_done;
  logic halt_fail;

  int n_checks = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int req_hi_cnt = 0;
  int done_run = 0;
  int done_run_max = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  port_halt_seq u0 (
    .clk(clk), .rst(rst), .halt_cmd(halt_cmd), .ms_tick(ms_tick),
    .port_idle(port_idle), .port_ack(port_ack),
    .halt_req(halt_req), .halt_done(halt_done), .halt_fail(halt_fail)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (halt_done) begin
        done_cnt++;
        done_run++;
        if (done_run > done_run_max) done_run_max = done_run;
      end else begin
        done_run = 0;
      end
      if (halt_req) req_hi_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int ack_at);
    return (ack_at <= LIMIT) ? ack_at : LIMIT;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_cmd();
    halt_cmd = 1'b1;
    @(negedge clk);
    halt_cmd = 1'b0;
  endtask

  task automatic pulse_tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  // One halt attempt. ack_at: tick number on which ack is present (NEVER = none).
  task automatic run_case(input bit pre_idle, input int ack_at, input bit end_idle,
                          input bit cmd_mid, input string tag);
    int d0;
    int r0;
    int ticks;
    d0 = done_cnt;
    port_idle = pre_idle;
    port_ack = 1'b0;
    cycles(4);
    r0 = req_hi_cnt;
    pulse_cmd();
    if (pre_idle) begin
      cycles(4);
      check({tag, " R2 done count"}, done_cnt - d0, 1);
      check({tag, " R2 no request"}, req_hi_cnt - r0, 0);
      check({tag, " R2 fail low"}, halt_fail, 0);
      return;
    end
    check({tag, " R3 request raised"}, halt_req, 1);
    port_idle = end_idle;
    ticks = 0;
    for (int k = 1; k <= LIMIT + 5; k++) begin
      if (k == ack_at) port_ack = 1'b1;
      cycles(4);
      if (cmd_mid && k == 3) pulse_cmd();
      if (k == LIMIT && ack_at > LIMIT)
        check({tag, " R5 request held before last tick"}, halt_req, 1);
      pulse_tick();
      ticks = k;
      cycles(1);
      if (done_cnt != d0) break;
      cycles(1);
      if (done_cnt != d0) break;
    end
    port_ack = 1'b0;
    check({tag, " R4/R5 ticks to completion"}, ticks, exp_ticks(ack_at));
    check({tag, " R7 request cleared"}, halt_req, 0);
    check({tag, " R6 fail from idle"}, halt_fail, end_idle ? 0 : 1);
    cycles(3);
    check({tag, " R8/R10 single done"}, done_cnt - d0, 1);
  endtask

  initial begin
    int seed;
    int ack_at;
    int d0;
    seed = 32'h5eed_0042;
    void'($urandom(seed));

    cycles(3);
    check("R1 req in reset", halt_req, 0);
    check("R1 done in reset", halt_done, 0);
    rst = 1'b0;
    cycles(1);
    check("R1 req after reset", halt_req, 0);
    check("R1 fail after reset", halt_fail, 0);

    run_case(1'b1, NEVER, 1'b1, 1'b0, "idle-path");
    run_case(1'b0, 1, 1'b1, 1'b0, "ack first tick");
    run_case(1'b0, 7, 1'b0, 1'b0, "ack but not idle");
    run_case(1'b0, NEVER, 1'b1, 1'b0, "timeout idle");
    run_case(1'b0, NEVER, 1'b0, 1'b0, "timeout busy");

    // R9: failure flag holds, then clears on acceptance
    cycles(20);
    check("R9 fail held", halt_fail, 1);
    run_case(1'b1, NEVER, 1'b1, 1'b0, "R9 clear");

    // coincidence: ack on the final budget tick
    run_case(1'b0, LIMIT, 1'b1, 1'b0, "ack on last tick");
    // R10: command during wait ignored
    run_case(1'b0, 12, 1'b1, 1'b1, "R10 cmd mid-wait");

    // R4: ack pulse between ticks is ignored
    port_idle = 1'b0;
    cycles(4);
    d0 = done_cnt;
    pulse_cmd();
    port_ack = 1'b1;
    cycles(4);
    port_ack = 1'b0;
    cycles(4);
    pulse_tick();
    cycles(4);
    check("R4 ack between ticks ignored", halt_req, 1);
    check("R4 no done yet", done_cnt - d0, 0);
    port_ack = 1'b1;
    port_idle = 1'b1;
    cycles(4);
    pulse_tick();
    cycles(1);
    check("R4 done two cycles after tick", halt_done, 1);
    port_ack = 1'b0;
    cycles(3);

    for (int t = 0; t < 25; t++) begin
      bit pi;
      bit ei;
      pi = ($urandom % 4) == 0;
      ei = $urandom % 2;
      ack_at = (($urandom % 5) == 0) ? NEVER : 1 + ($urandom % LIMIT);
      run_case(pi, ack_at, ei, ($urandom % 3) == 0, "random");
    end

    check("R8 done pulse width", done_run_max, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule